// File: doc/BRIEF.md
# Configurable Quadrature Decoder Front End

This block sits between the pads of an incremental encoder and a position counter. It takes the raw A, B, index and strobe lines and brings them into the clock domain through synchronizer flops. It then inverts any of the four lines on request and can exchange A with B. From the conditioned A and B it produces a single-cycle count pulse and a direction level, which is all a downstream counter needs to step up or down.

A static two-bit source select picks how A and B are read. The options are full quadrature decode at four counts per cycle, clock-plus-direction, or an external clock with the direction forced up or forced down. In the three non-quadrature sources a rate bit chooses between counting both edges of the clock line and counting only its rising edges. The block flags each reversal of the decoded direction and each invalid quadrature step. It forwards the index line, optionally qualified by the A/B state, and the strobe line with its polarity applied.

Top module: `qdec_frontend`

## Requirements
- R1: Each raw input passes through two synchronizer flops, and every output is registered. A raw input change set up before clock edge k shows on the outputs just after edge k+2 and not earlier.
- R2: `inv_a`, `inv_b`, `inv_idx` and `inv_strb` invert the physical pin of the same name. After that inversion, `swap_ab`=1 exchanges A and B. `strb_out` is the strobe pin with its inversion applied.
- R3: With `src_sel`=0 (quadrature), each sample in which exactly one of A or B changed gives one `cnt_pulse`. The direction is forward (1) when A leads B, meaning the {A,B} sequence runs 00, 10, 11, 01. It is reverse (0) for the opposite order.
- R4: In quadrature mode, a sample in which A and B both changed raises `phase_err` for one cycle. It gives no `cnt_pulse` and leaves `dir_state` unchanged.
- R5: With `src_sel`=1 (clock-plus-direction), A is the count clock, and the direction of each count is the level of B in the same sample.
- R6: With `src_sel`=2, A is the count clock and every count is forward (1). With `src_sel`=3, A is the count clock and every count is reverse (0).
- R7: In the non-quadrature sources, `rate_1x`=0 counts both the rising and the falling edges of A, and `rate_1x`=1 counts only its rising edges.
- R8: `dir_state` holds the direction of the most recent count. `dir_chg` pulses for one cycle, together with `cnt_pulse`, whenever a count's direction differs from the direction held before it.
- R9: `idx_out` is the conditioned index. When `idx_gate_en`=1 it is high only while the conditioned A and B are both high.
- R10: Outside quadrature mode `phase_err` never rises, and a simultaneous change of A and B still counts as a clock edge.
- R11: While `rst_n` is low, `cnt_pulse`, `dir_chg`, `phase_err`, `idx_out` and `strb_out` are 0 and `dir_state` is 1. No event is reported from the reset values of the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_a | input | 1 | Raw encoder A line |
| enc_b | input | 1 | Raw encoder B line |
| enc_idx | input | 1 | Raw index line |
| enc_strb | input | 1 | Raw strobe line |
| src_sel | input | 2 | Count source: 0 quadrature, 1 clock+direction, 2 up, 3 down |
| rate_1x | input | 1 | Non-quadrature sources: 1 rising edges only, 0 both edges |
| swap_ab | input | 1 | Exchange A and B after inversion |
| inv_a | input | 1 | Invert the A pin |
| inv_b | input | 1 | Invert the B pin |
| inv_idx | input | 1 | Invert the index pin |
| inv_strb | input | 1 | Invert the strobe pin |
| idx_gate_en | input | 1 | Pass the index only while A and B are high |
| cnt_pulse | output | 1 | One-cycle count strobe |
| dir_state | output | 1 | Direction of the latest count (1 forward) |
| dir_chg | output | 1 | One-cycle pulse on a direction reversal |
| phase_err | output | 1 | One-cycle pulse on an invalid quadrature step |
| idx_out | output | 1 | Conditioned, optionally gated index |
| strb_out | output | 1 | Conditioned strobe |

## Verification
Every result of this block is due on the third rising edge after its raw input was set up: two synchronizer edges, then the output register. This holds for count pulses, flags and the forwarded index and strobe alike. The bench drives inputs on the falling edge and advances a reference pipeline of the same three stages in step with it. It compares all six outputs on the next falling edge, so each expectation is tied to its own edge count. The directed cases also look at the two falling edges before the due edge, to show that nothing appears early.

// File: rtl/qdec_pkg.sv
// Shared definitions for the quadrature decoder front end.
// Assumes the four encoder lines travel packed in the bit order given here.
package qdec_pkg;

    localparam int NUM_PINS = 4;
    localparam int BIT_A    = 0;
    localparam int BIT_B    = 1;
    localparam int BIT_IDX  = 2;
    localparam int BIT_STRB = 3;

    typedef enum logic [1:0] {
        SRC_QUAD   = 2'd0,
        SRC_CLKDIR = 2'd1,
        SRC_UP     = 2'd2,
        SRC_DOWN   = 2'd3
    } src_mode_t;

endpackage

// File: rtl/qdec_sync.sv
// Multi-flop synchronizer for a bus of independent single-bit lines.
// Assumes each line is asynchronous and that bits need not stay coherent
// with one another. Reset drives every stage to 0.
module qdec_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_in;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        // Each later stage re-samples the one before it.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_q[g-1];
        end
    end

    assign sync_out = stage_q[LAST];

endmodule

// File: rtl/qdec_cond.sv
// Input conditioner: per-pin inversion, then optional A/B exchange, then
// index qualification. Purely combinational; assumes synchronized inputs.
module qdec_cond
    import qdec_pkg::*;
(
    input  logic [NUM_PINS-1:0] pins_s,
    input  logic                swap_ab,
    input  logic                inv_a,
    input  logic                inv_b,
    input  logic                inv_idx,
    input  logic                inv_strb,
    input  logic                idx_gate_en,
    output logic                a_c,
    output logic                b_c,
    output logic                idx_c,
    output logic                strb_c
);

    logic pin_a_p;
    logic pin_b_p;
    logic idx_p;

    // Inversion on physical pins, exchange afterwards, gate index on A&B.
    always_comb begin
        pin_a_p = pins_s[BIT_A] ^ inv_a;
        pin_b_p = pins_s[BIT_B] ^ inv_b;
        a_c     = swap_ab ? pin_b_p : pin_a_p;
        b_c     = swap_ab ? pin_a_p : pin_b_p;
        idx_p   = pins_s[BIT_IDX] ^ inv_idx;
        idx_c   = idx_p & (~idx_gate_en | (a_c & b_c));
        strb_c  = pins_s[BIT_STRB] ^ inv_strb;
    end

endmodule

// File: rtl/qdec_core.sv
// Decode engine: compares the conditioned A/B with the previous sample and
// produces registered count, direction and error outputs for the chosen
// source. Assumes static configuration while out of reset. The previous
// sample resets to the current conditioned value so reset reports nothing.
module qdec_core
    import qdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       rate_1x,
    input  logic       a_c,
    input  logic       b_c,
    input  logic       idx_c,
    input  logic       strb_c,
    output logic       cnt_pulse,
    output logic       dir_state,
    output logic       dir_chg,
    output logic       phase_err,
    output logic       idx_out,
    output logic       strb_out
);

    src_mode_t  mode;
    logic [1:0] prev_ab;
    logic       chg_a;
    logic       chg_b;
    logic       clk_edge;
    logic       ev_c;
    logic       err_c;
    logic       dir_c;

    assign mode = src_mode_t'(src_sel);

    // Classify the current sample against the previous one.
    always_comb begin
        chg_a    = a_c ^ prev_ab[1];
        chg_b    = b_c ^ prev_ab[0];
        clk_edge = chg_a & (~rate_1x | a_c);
        ev_c     = 1'b0;
        err_c    = 1'b0;
        dir_c    = dir_state;
        case (mode)
            SRC_QUAD: begin
                ev_c  = chg_a ^ chg_b;
                err_c = chg_a & chg_b;
                dir_c = chg_a ? (a_c ^ b_c) : ~(a_c ^ b_c);
            end
            SRC_CLKDIR: begin
                ev_c  = clk_edge;
                dir_c = b_c;
            end
            SRC_UP: begin
                ev_c  = clk_edge;
                dir_c = 1'b1;
            end
            default: begin
                ev_c  = clk_edge;
                dir_c = 1'b0;
            end
        endcase
    end

    // Register events, direction state and forwarded index/strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ab   <= {a_c, b_c};
            cnt_pulse <= 1'b0;
            dir_state <= 1'b1;
            dir_chg   <= 1'b0;
            phase_err <= 1'b0;
            idx_out   <= 1'b0;
            strb_out  <= 1'b0;
        end else begin
            prev_ab   <= {a_c, b_c};
            cnt_pulse <= ev_c;
            dir_chg   <= ev_c & (dir_c != dir_state);
            phase_err <= err_c;
            idx_out   <= idx_c;
            strb_out  <= strb_c;
            if (ev_c) dir_state <= dir_c;
        end
    end

endmodule

// File: rtl/qdec_frontend.sv
// Top of the quadrature decoder front end: synchronizer, conditioner and
// decode engine in series. Assumes all configuration ports are static
// while out of reset.
module qdec_frontend
    import qdec_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enc_a,
    input  logic       enc_b,
    input  logic       enc_idx,
    input  logic       enc_strb,
    input  logic [1:0] src_sel,
    input  logic       rate_1x,
    input  logic       swap_ab,
    input  logic       inv_a,
    input  logic       inv_b,
    input  logic       inv_idx,
    input  logic       inv_strb,
    input  logic       idx_gate_en,
    output logic       cnt_pulse,
    output logic       dir_state,
    output logic       dir_chg,
    output logic       phase_err,
    output logic       idx_out,
    output logic       strb_out
);

    logic [NUM_PINS-1:0] pins_raw;
    logic [NUM_PINS-1:0] pins_s;
    logic                a_c;
    logic                b_c;
    logic                idx_c;
    logic                strb_c;

    // Pack the raw pins in package bit order.
    always_comb begin
        pins_raw           = '0;
        pins_raw[BIT_A]    = enc_a;
        pins_raw[BIT_B]    = enc_b;
        pins_raw[BIT_IDX]  = enc_idx;
        pins_raw[BIT_STRB] = enc_strb;
    end

    qdec_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins_raw),
        .sync_out (pins_s)
    );

    qdec_cond u_cond (
        .pins_s      (pins_s),
        .swap_ab     (swap_ab),
        .inv_a       (inv_a),
        .inv_b       (inv_b),
        .inv_idx     (inv_idx),
        .inv_strb    (inv_strb),
        .idx_gate_en (idx_gate_en),
        .a_c         (a_c),
        .b_c         (b_c),
        .idx_c       (idx_c),
        .strb_c      (strb_c)
    );

    qdec_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_sel   (src_sel),
        .rate_1x   (rate_1x),
        .a_c       (a_c),
        .b_c       (b_c),
        .idx_c     (idx_c),
        .strb_c    (strb_c),
        .cnt_pulse (cnt_pulse),
        .dir_state (dir_state),
        .dir_chg   (dir_chg),
        .phase_err (phase_err),
        .idx_out   (idx_out),
        .strb_out  (strb_out)
    );

endmodule

// File: rtl/qdec_frontend_checker.sv
// Protocol checker for the decoder front end, bound to the top module.
// Assumes configuration is static while out of reset.
module qdec_frontend_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] src_sel,
    input logic       cnt_pulse,
    input logic       dir_state,
    input logic       dir_chg,
    input logic       phase_err
);

    AST_PULSE_NOT_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(cnt_pulse && phase_err)); // R4

    AST_ERR_HOLDS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        phase_err |-> $stable(dir_state)); // R4

    AST_ERR_QUAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        phase_err |-> (src_sel == 2'd0)); // R10

    AST_DIR_MOVES_ON_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_state != $past(dir_state)) |-> cnt_pulse); // R8

    AST_CHG_MEANS_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        dir_chg |-> (cnt_pulse && (dir_state != $past(dir_state)))); // R8

    AST_UP_IS_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'd2 && cnt_pulse) |-> dir_state); // R6

    AST_DOWN_IS_REVERSE: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'd3 && cnt_pulse) |-> !dir_state); // R6

endmodule

bind qdec_frontend qdec_frontend_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_sel   (src_sel),
    .cnt_pulse (cnt_pulse),
    .dir_state (dir_state),
    .dir_chg   (dir_chg),
    .phase_err (phase_err)
);

// File: tb/qdec_frontend_bench.sv
module qdec_frontend_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enc_a = 0, enc_b = 0, enc_idx = 0, enc_strb = 0;
    logic [1:0] src_sel = 2'd0;
    logic rate_1x = 0, swap_ab = 0, inv_a = 0, inv_b = 0;
    logic inv_idx = 0, inv_strb = 0, idx_gate_en = 0;
    logic cnt_pulse, dir_state, dir_chg, phase_err, idx_out, strb_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    qdec_frontend u_qdec_frontend (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .enc_idx(enc_idx), .enc_strb(enc_strb), .src_sel(src_sel),
        .rate_1x(rate_1x), .swap_ab(swap_ab), .inv_a(inv_a), .inv_b(inv_b),
        .inv_idx(inv_idx), .inv_strb(inv_strb), .idx_gate_en(idx_gate_en),
        .cnt_pulse(cnt_pulse), .dir_state(dir_state), .dir_chg(dir_chg),
        .phase_err(phase_err), .idx_out(idx_out), .strb_out(strb_out)
    );

    // Reference pipeline state; raw vectors are {a, b, idx, strb}.
    logic [3:0] m_s1, m_s2;
    logic [1:0] m_prev;
    logic m_pulse, m_dir, m_chg, m_err, m_idx, m_strb;

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b (src=%0d t=%0t)",
                     req, act, exp, src_sel, $time);
        end
    endtask

    // Conditioned view of a synchronized vector, per R2 and R9.
    function automatic logic [3:0] cond(input logic [3:0] s);
        logic pa, pb, a, b, i;
        pa = s[3] ^ inv_a;
        pb = s[2] ^ inv_b;
        a  = swap_ab ? pb : pa;
        b  = swap_ab ? pa : pb;
        i  = (s[1] ^ inv_idx) & (!idx_gate_en | (a & b));
        return {a, b, i, s[0] ^ inv_strb};
    endfunction

    function automatic string ptag();
        case (src_sel)
            2'd0:    return "R3";
            2'd1:    return "R5_R7";
            default: return "R6_R7";
        endcase
    endfunction

    task automatic model_reset();
        logic [3:0] c;
        m_s1 = '0; m_s2 = '0;
        c = cond(4'b0000);
        m_prev = c[3:2];
        m_pulse = 0; m_dir = 1; m_chg = 0; m_err = 0; m_idx = 0; m_strb = 0;
    endtask

    // One rising edge of the reference: R3..R8, R10.
    task automatic model_edge(input logic [3:0] raw);
        logic [3:0] c;
        logic a, b, da, db, ev, er, d, clk_e;
        c = cond(m_s2);
        a = c[3]; b = c[2];
        da = a ^ m_prev[1]; db = b ^ m_prev[0];
        clk_e = da && (!rate_1x || a);
        er = 0;
        case (src_sel)
            2'd0: begin ev = da ^ db; er = da & db; d = da ? (a ^ b) : !(a ^ b); end
            2'd1: begin ev = clk_e; d = b; end
            2'd2: begin ev = clk_e; d = 1; end
            default: begin ev = clk_e; d = 0; end
        endcase
        m_pulse = ev;
        m_err   = er;
        m_chg   = ev && (d != m_dir);
        if (ev) m_dir = d;
        m_idx  = c[1];
        m_strb = c[0];
        m_prev = {a, b};
        m_s2 = m_s1;
        m_s1 = raw;
    endtask

    // Drive at a falling edge, advance the model, compare at the next falling edge.
    task automatic cycle(input logic [3:0] raw);
        {enc_a, enc_b, enc_idx, enc_strb} = raw;
        model_edge(raw);
        @(negedge clk);
        chk(ptag(), cnt_pulse, m_pulse);
        chk("R4",   phase_err, m_err);
        chk("R8",   dir_state, m_dir);
        chk("R8",   dir_chg,   m_chg);
        chk("R9",   idx_out,   m_idx);
        chk("R2",   strb_out,  m_strb);
    endtask

    task automatic do_reset();
        rst_n = 0;
        {enc_a, enc_b, enc_idx, enc_strb} = 4'b0000;
        repeat (3) @(negedge clk);
        chk("R11", cnt_pulse, 1'b0);
        chk("R11", dir_state, 1'b1);
        chk("R11", dir_chg,   1'b0);
        chk("R11", phase_err, 1'b0);
        chk("R11", idx_out,   1'b0);
        chk("R11", strb_out,  1'b0);
        model_reset();
        rst_n = 1;
        repeat (3) cycle(4'b0000);
    endtask

    task automatic set_cfg(input logic [1:0] s, input logic r, input logic sw,
                           input logic [3:0] inv, input logic g);
        src_sel = s; rate_1x = r; swap_ab = sw;
        {inv_a, inv_b, inv_idx, inv_strb} = inv; idx_gate_en = g;
    endtask

    initial begin
        logic [3:0] cur;
        void'($urandom(32'd20240611));
        @(negedge clk);

        // R1/R3/R11: one A rise in quadrature mode, due on the third edge.
        set_cfg(2'd0, 0, 0, 4'b0000, 0);
        do_reset();
        cycle(4'b1000); chk("R1", cnt_pulse, 1'b0);
        cycle(4'b1000); chk("R1", cnt_pulse, 1'b0);
        cycle(4'b1000); chk("R1", cnt_pulse, 1'b1); chk("R3", dir_state, 1'b1);
        cycle(4'b1100); cycle(4'b1100); cycle(4'b1100);
        chk("R3", cnt_pulse, 1'b1); chk("R3", dir_state, 1'b1);

        // R2/R8: swapped, pin A rise decodes as B leading -> reverse.
        set_cfg(2'd0, 0, 1, 4'b0000, 0);
        do_reset();
        repeat (3) cycle(4'b1000);
        chk("R2", dir_state, 1'b0); chk("R8", dir_chg, 1'b1);

        // R4: both lines change together.
        set_cfg(2'd0, 0, 0, 4'b0000, 0);
        do_reset();
        repeat (3) cycle(4'b1100);
        chk("R4", phase_err, 1'b1); chk("R4", cnt_pulse, 1'b0); chk("R4", dir_state, 1'b1);

        // R7/R5: rising-only clock; the falling A edge must not count.
        set_cfg(2'd1, 1, 0, 4'b0000, 0);
        do_reset();
        repeat (3) cycle(4'b1000);
        chk("R7", cnt_pulse, 1'b1); chk("R5", dir_state, 1'b0);
        for (int k = 0; k < 4; k++) begin
            cycle(4'b0000);
            chk("R7", cnt_pulse, 1'b0);
        end

        // R6/R10: down source, A and B toggled together.
        set_cfg(2'd3, 0, 0, 4'b0000, 0);
        do_reset();
        repeat (3) cycle(4'b1100);
        chk("R6", cnt_pulse, 1'b1); chk("R6", dir_state, 1'b0);
        chk("R10", phase_err, 1'b0);

        // R9: gated index blocked while A/B low, passed when both high.
        set_cfg(2'd2, 0, 0, 4'b0000, 1);
        do_reset();
        repeat (4) cycle(4'b0010);
        chk("R9", idx_out, 1'b0);
        repeat (3) cycle(4'b1110);
        chk("R9", idx_out, 1'b1);

        // Random configurations and streams against the reference.
        for (int sc = 0; sc < 40; sc++) begin
            set_cfg(2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2),
                    4'($urandom % 16), 1'($urandom % 2));
            do_reset();
            cur = 4'b0000;
            for (int n = 0; n < 250; n++) begin
                int r;
                r = int'($urandom % 100);
                if (src_sel == 2'd0) begin
                    if (r >= 90)      cur[3:2] = ~cur[3:2];
                    else if (r >= 60) begin
                        if ($urandom % 2 == 0) cur[3] = ~cur[3];
                        else                   cur[2] = ~cur[2];
                    end
                end else begin
                    if ($urandom % 3 == 0) cur[3] = ~cur[3];
                    if ($urandom % 4 == 0) cur[2] = ~cur[2];
                end
                if ($urandom % 5 == 0) cur[1] = ~cur[1];
                if ($urandom % 5 == 0) cur[0] = ~cur[0];
                cycle(cur);
            end
        end

        report();
    end

endmodule